// File: doc/BRIEF.md
# Calendar Clock with Alarm and Watchdog Interrupts

A synthesizable time-of-day and calendar core for a system that receives a 32.768 kHz reference as a single-cycle enable pulse in its own clock domain. A prescaler turns the reference pulses into a one-second tick and into a 1/32-second tick. The seconds tick drives BCD counters for second, minute, hour, weekday, day of month, month and two-digit year. Month lengths follow the calendar, and February has 29 days in any year divisible by four.

Three event sources set sticky flags: a match against an alarm target, the expiry of a restartable watchdog count, and an external power-fail level. The alarm can fire once or repeat every second, minute, hour or day. Each flag has its own enable toward a single interrupt pin. That pin is driven either as an active-high push-pull signal or as an active-low open-drain signal, where the output enable carries the request and the level stays low.

Software reaches everything through a 16-location byte map with a combinational read port. A freeze bit gives a coherent multi-byte read of the time. A write-enable bit guards the time fields against stray writes.

Top module: `rtc_alarm_wdog`

## Requirements
- R1: Seconds advance once every PRESCALE reference pulses. A permitted write to the seconds location (address 0) restarts the prescaler, so the time advances at the clock edge exactly PRESCALE reference pulses after that write.
- R2: Seconds and minutes count 00..59 in BCD, and hours count 00..23. Weekday (address 3) counts 1..7 and wraps from 7 to 1 when the hour wraps.
- R3: Day of month (address 4) wraps to 01 after 31, 30, 28 or 29 according to month (address 5) and year (address 6). February has 29 days when the binary value of the BCD year is divisible by 4. Month wraps from 12 to 01, and that wrap increments the year, which goes from 99 to 00.
- R4: Alarm mode (address 11, bits 2:0) selects the match: 0 off, 1 once (date, hour, minute and second), 2 every second, 3 when the second matches, 4 when minute and second match, 5 when hour, minute and second match. Codes 6 and 7 act as off. The alarm targets are second (address 7), minute (8), hour (9) and date (10). The match is evaluated on the newly advanced time.
- R5: After a mode-1 alarm fires, the mode field reads 0.
- R6: The watchdog location (address 12) holds a count in bits 5:0 and a unit in bit 7 (0 = 1/32 s, 1 = 1 s). Every write reloads the count and restarts it. The flag sets when the count expires after that many units. A count of 0 never expires.
- R7: Flag register (address 14): bit 0 alarm, bit 1 watchdog, bit 2 power-fail (set while the input is high). Flags stay set until a read of address 14 clears them. The read returns the value from before the clear.
- R8: Mask register (address 13) bits 0..2 enable the corresponding flags toward the interrupt. With no enabled flag set, the interrupt is inactive.
- R9: Mask bit 7 = 1 selects push-pull: the enable is always 1 and the level shows the request. Mask bit 7 = 0 selects open-drain: the level is always 0 and the enable shows the request.
- R10: Control (address 15) bit 1 is a write enable. While it is 0, writes to addresses 0..6 change nothing.
- R11: Control bit 0 freezes a copy of addresses 0..6 for reads. The live time keeps running, and reads show it again once the bit is cleared.
- R12: After reset the time reads 00:00:00 with weekday 1, date 01, month 01 and year 00. Flags, masks, alarm mode and control are 0, and the interrupt pins are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle pulse per reference oscillator period |
| pwr_fail_i | input | 1 | Power-fail level from the supply monitor |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | Write strobe, qualified by sel_i |
| rd_i | input | 1 | Read strobe, qualified by sel_i; clears flags at address 14 |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt level |
| irq_oe_o | output | 1 | Interrupt output enable |

## Verification
The bench builds the block with PRESCALE = 64 and FRACS = 32, and pulses the reference on every clock. One second is then 64 cycles and one watchdog fraction is 2 cycles. With those values the bench can sweep every month-end across sixteen years that cover both tens-digit parities of the leap rule. Every alarm mode can be driven through matching and non-matching seconds, and watchdog expiry can be checked to within a cycle or two in both units. The exact cycle at which the seconds field changes after a seconds write is sampled on both sides of the edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
  } rtc_time_t;

  typedef enum logic [2:0] {
    ALM_OFF  = 3'd0,
    ALM_ONCE = 3'd1,
    ALM_SEC  = 3'd2,
    ALM_MIN  = 3'd3,
    ALM_HOUR = 3'd4,
    ALM_DAY  = 3'd5
  } alm_mode_e;

  localparam logic [3:0] ADR_SEC   = 4'd0;
  localparam logic [3:0] ADR_MIN   = 4'd1;
  localparam logic [3:0] ADR_HOUR  = 4'd2;
  localparam logic [3:0] ADR_DAY   = 4'd3;
  localparam logic [3:0] ADR_DATE  = 4'd4;
  localparam logic [3:0] ADR_MONTH = 4'd5;
  localparam logic [3:0] ADR_YEAR  = 4'd6;
  localparam logic [3:0] ADR_ASEC  = 4'd7;
  localparam logic [3:0] ADR_AMIN  = 4'd8;
  localparam logic [3:0] ADR_AHOUR = 4'd9;
  localparam logic [3:0] ADR_ADATE = 4'd10;
  localparam logic [3:0] ADR_AMODE = 4'd11;
  localparam logic [3:0] ADR_WDOG  = 4'd12;
  localparam logic [3:0] ADR_MASK  = 4'd13;
  localparam logic [3:0] ADR_FLAG  = 4'd14;
  localparam logic [3:0] ADR_CTL   = 4'd15;

  // next BCD value, wrapping from lim to base
  function automatic logic [7:0] bcd_next(logic [7:0] v, logic [7:0] lim, logic [7:0] base);
    if (v == lim)            return base;
    else if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                     return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of month, BCD in and out
  function automatic logic [7:0] month_len(logic [7:0] month, logic [7:0] year);
    logic [4:0] m4;
    m4 = {year[7:4], 1'b0} + {1'b0, year[3:0]};  // (10t+o) mod 4 == (2t+o) mod 4
    case (month)
      8'h02:                     return (m4[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESCALE = 32768,
  parameter int unsigned FRACS    = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic restart_i,
  output logic frac_tick_o,
  output logic sec_tick_o
);
  localparam int unsigned FRAC_DIV = PRESCALE / FRACS;
  localparam int unsigned CW = $clog2(PRESCALE);
  localparam int unsigned FW = (FRAC_DIV > 1) ? $clog2(FRAC_DIV) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(PRESCALE - 1);
  localparam logic [FW-1:0] SUB_MAX = FW'(FRAC_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [FW-1:0] sub_q;

  assign sec_tick_o  = ref_tick_i && !restart_i && (cnt_q == CNT_MAX);
  assign frac_tick_o = ref_tick_i && !restart_i && (sub_q == SUB_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (ref_tick_i) begin
      cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
      sub_q <= (sub_q == SUB_MAX) ? '0 : sub_q + 1'b1;
    end
  end

  AST_SEC_ON_FRAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> frac_tick_o); // R1
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output rtc_time_t  time_o
);
  rtc_time_t  t_q, t_n;
  logic       c_s, c_m, c_h, c_d, c_mo;
  logic [7:0] mlen;

  always_comb begin
    mlen = month_len(t_q.month, t_q.year);
    c_s  = (t_q.sec == 8'h59);
    c_m  = c_s && (t_q.min == 8'h59);
    c_h  = c_m && (t_q.hour == 8'h23);
    c_d  = c_h && (t_q.date == mlen);
    c_mo = c_d && (t_q.month == 8'h12);
    t_n       = t_q;
    t_n.sec   = bcd_next(t_q.sec, 8'h59, 8'h00);
    if (c_s)  t_n.min   = bcd_next(t_q.min, 8'h59, 8'h00);
    if (c_m)  t_n.hour  = bcd_next(t_q.hour, 8'h23, 8'h00);
    if (c_h)  t_n.day   = bcd_next(t_q.day, 8'h07, 8'h01);
    if (c_h)  t_n.date  = bcd_next(t_q.date, mlen, 8'h01);
    if (c_d)  t_n.month = bcd_next(t_q.month, 8'h12, 8'h01);
    if (c_mo) t_n.year  = bcd_next(t_q.year, 8'h99, 8'h00);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01,
               date: 8'h01, month: 8'h01, year: 8'h00};
    end else if (wr_i) begin
      case (wr_addr_i)
        3'd0: t_q.sec   <= wr_data_i;
        3'd1: t_q.min   <= wr_data_i;
        3'd2: t_q.hour  <= wr_data_i;
        3'd3: t_q.day   <= wr_data_i;
        3'd4: t_q.date  <= wr_data_i;
        3'd5: t_q.month <= wr_data_i;
        3'd6: t_q.year  <= wr_data_i;
        default: ;
      endcase
    end else if (tick_i) begin
      t_q <= t_n;
    end
  end

  assign time_o = t_q;

  AST_HOUR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && c_h) |=> (t_q.hour == 8'h00 && t_q.min == 8'h00 && t_q.sec == 8'h00)); // R2
  AST_YEAR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && c_mo && t_q.year == 8'h99) |=>
    (t_q.year == 8'h00 && t_q.month == 8'h01 && t_q.date == 8'h01)); // R3
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       eval_i,
  input  alm_mode_e  mode_i,
  input  logic [7:0] sec_i,
  input  logic [7:0] min_i,
  input  logic [7:0] hour_i,
  input  logic [7:0] date_i,
  input  logic [7:0] a_sec_i,
  input  logic [7:0] a_min_i,
  input  logic [7:0] a_hour_i,
  input  logic [7:0] a_date_i,
  output logic       fire_o
);
  logic m_s, m_m, m_h, m_d, hit;

  always_comb begin
    m_s = (sec_i == a_sec_i);
    m_m = (min_i == a_min_i);
    m_h = (hour_i == a_hour_i);
    m_d = (date_i == a_date_i);
    case (mode_i)
      ALM_ONCE: hit = m_s && m_m && m_h && m_d;
      ALM_SEC:  hit = 1'b1;
      ALM_MIN:  hit = m_s;
      ALM_HOUR: hit = m_s && m_m;
      ALM_DAY:  hit = m_s && m_m && m_h;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fire_o <= 1'b0;
    else         fire_o <= eval_i && hit;
  end

  AST_FIRE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(eval_i)); // R4
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frac_tick_i,
  input  logic             sec_tick_i,
  input  logic             load_i,
  input  logic             unit_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             unit_q;
  logic             step;

  assign step = unit_q ? sec_tick_i : frac_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      unit_q   <= 1'b0;
      expire_o <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      unit_q   <= unit_i;
      expire_o <= 1'b0;
    end else if (step && cnt_q != '0) begin
      cnt_q    <= cnt_q - 1'b1;
      expire_o <= (cnt_q == CNT_W'(1));
    end else begin
      expire_o <= 1'b0;
    end
  end

  AST_WDOG_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (cnt_q == '0)); // R6
  AST_WDOG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> !expire_o); // R6
endmodule

// File: rtl/rtc_alarm_wdog.sv
module rtc_alarm_wdog
  import rtc_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768,
  parameter int unsigned FRACS    = 32,
  parameter int unsigned WDOG_W   = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_tick_i,
  input  logic       pwr_fail_i,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       irq_oe_o
);
  localparam int unsigned NSRC = 3;

  logic            wr_stb, cal_wr, restart, amode_wr, wdog_wr, rd_clr;
  logic            frac_tick, sec_tick, tick_q, alarm_fire, wdog_exp, irq_req;
  rtc_time_t       time_w, snap_q, time_rd;
  logic [7:0]      a_sec_q, a_min_q, a_hour_q, a_date_q;
  alm_mode_e       amode_q;
  logic [WDOG_W-1:0] wd_val_q;
  logic            wd_unit_q;
  logic [NSRC-1:0] mask_q, flags_q, flag_set;
  logic            pol_q, hold_q, we_q;
  logic [7:0]      wdog_rb;

  assign wr_stb   = sel_i && wr_i;
  assign cal_wr   = wr_stb && we_q && (addr_i < 4'd7);
  assign restart  = cal_wr && (addr_i == ADR_SEC);
  assign amode_wr = wr_stb && (addr_i == ADR_AMODE);
  assign wdog_wr  = wr_stb && (addr_i == ADR_WDOG);
  assign rd_clr   = sel_i && rd_i && (addr_i == ADR_FLAG);

  rtc_prescaler #(.PRESCALE(PRESCALE), .FRACS(FRACS)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .restart_i(restart),
    .frac_tick_o(frac_tick), .sec_tick_o(sec_tick)
  );

  rtc_calendar u_cal (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(sec_tick), .wr_i(cal_wr),
    .wr_addr_i(addr_i[2:0]), .wr_data_i(wdata_i), .time_o(time_w)
  );

  rtc_alarm u_alm (
    .clk_i(clk_i), .rst_ni(rst_ni), .eval_i(tick_q), .mode_i(amode_q),
    .sec_i(time_w.sec), .min_i(time_w.min), .hour_i(time_w.hour), .date_i(time_w.date),
    .a_sec_i(a_sec_q), .a_min_i(a_min_q), .a_hour_i(a_hour_q), .a_date_i(a_date_q),
    .fire_o(alarm_fire)
  );

  rtc_wdog #(.CNT_W(WDOG_W)) u_wd (
    .clk_i(clk_i), .rst_ni(rst_ni), .frac_tick_i(frac_tick), .sec_tick_i(sec_tick),
    .load_i(wdog_wr), .unit_i(wdata_i[7]), .load_val_i(wdata_i[WDOG_W-1:0]),
    .expire_o(wdog_exp)
  );

  assign flag_set = {pwr_fail_i, wdog_exp, alarm_fire};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q    <= 1'b0;
      snap_q    <= '0;
      a_sec_q   <= '0;
      a_min_q   <= '0;
      a_hour_q  <= '0;
      a_date_q  <= '0;
      amode_q   <= ALM_OFF;
      wd_val_q  <= '0;
      wd_unit_q <= 1'b0;
      mask_q    <= '0;
      pol_q     <= 1'b0;
      flags_q   <= '0;
      hold_q    <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      tick_q  <= sec_tick && !cal_wr;
      if (!hold_q) snap_q <= time_w;
      flags_q <= (rd_clr ? '0 : flags_q) | flag_set;
      if (amode_wr)
        amode_q <= alm_mode_e'(wdata_i[2:0]);
      else if (alarm_fire && amode_q == ALM_ONCE)
        amode_q <= ALM_OFF;
      if (wr_stb) begin
        case (addr_i)
          ADR_ASEC:  a_sec_q  <= wdata_i;
          ADR_AMIN:  a_min_q  <= wdata_i;
          ADR_AHOUR: a_hour_q <= wdata_i;
          ADR_ADATE: a_date_q <= wdata_i;
          ADR_WDOG: begin
            wd_val_q  <= wdata_i[WDOG_W-1:0];
            wd_unit_q <= wdata_i[7];
          end
          ADR_MASK: begin
            mask_q <= wdata_i[NSRC-1:0];
            pol_q  <= wdata_i[7];
          end
          ADR_CTL: begin
            hold_q <= wdata_i[0];
            we_q   <= wdata_i[1];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    wdog_rb            = '0;
    wdog_rb[WDOG_W-1:0] = wd_val_q;
    wdog_rb[7]         = wd_unit_q;
  end

  assign time_rd = hold_q ? snap_q : time_w;

  always_comb begin
    case (addr_i)
      ADR_SEC:   rdata_o = time_rd.sec;
      ADR_MIN:   rdata_o = time_rd.min;
      ADR_HOUR:  rdata_o = time_rd.hour;
      ADR_DAY:   rdata_o = time_rd.day;
      ADR_DATE:  rdata_o = time_rd.date;
      ADR_MONTH: rdata_o = time_rd.month;
      ADR_YEAR:  rdata_o = time_rd.year;
      ADR_ASEC:  rdata_o = a_sec_q;
      ADR_AMIN:  rdata_o = a_min_q;
      ADR_AHOUR: rdata_o = a_hour_q;
      ADR_ADATE: rdata_o = a_date_q;
      ADR_AMODE: rdata_o = {5'd0, amode_q};
      ADR_WDOG:  rdata_o = wdog_rb;
      ADR_MASK:  rdata_o = {pol_q, 4'd0, mask_q};
      ADR_FLAG:  rdata_o = {5'd0, flags_q};
      default:   rdata_o = {6'd0, we_q, hold_q};
    endcase
  end

  assign irq_req  = |(flags_q & mask_q);
  assign irq_o    = pol_q && irq_req;
  assign irq_oe_o = pol_q || irq_req;

  AST_ONCE_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_fire && amode_q == ALM_ONCE && !amode_wr) |=> (amode_q == ALM_OFF)); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && flag_set == '0) |=> (flags_q == '0)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[0] && !rd_clr) |=> flags_q[0]); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_q & mask_q) == '0) |-> (!irq_o && irq_oe_o == pol_q)); // R8
  AST_SNAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && $past(hold_q)) |-> $stable(snap_q)); // R11
endmodule

// File: tb/sim_rtc_alarm_wdog.sv
module sim_rtc_alarm_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_tick = 1'b1, pwr_fail = 1'b0;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq, irq_oe;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_wdog #(.PRESCALE(PRE), .FRACS(32), .WDOG_W(6)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .pwr_fail_i(pwr_fail),
    .sel_i(sel), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .irq_oe_o(irq_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
  endtask

  // seconds written first and last: no tick can land between the field writes
  task automatic set_time(input logic [7:0] h, m, s, dw, dt, mo, yr);
    wr_reg(4'd15, 8'h02);
    wr_reg(4'd0, s);
    wr_reg(4'd2, h);
    wr_reg(4'd1, m);
    wr_reg(4'd3, dw);
    wr_reg(4'd4, dt);
    wr_reg(4'd5, mo);
    wr_reg(4'd6, yr);
    wr_reg(4'd0, s);
  endtask

  function automatic logic [7:0] to_bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic alarm_case(input string tag, input logic [7:0] mode, ah, am, as, ad,
                            input logic [7:0] th, tm, ts, td, e1, e2);
    logic [7:0] v;
    wr_reg(4'd7, as);
    wr_reg(4'd8, am);
    wr_reg(4'd9, ah);
    wr_reg(4'd10, ad);
    wr_reg(4'd11, mode);
    set_time(th, tm, ts, 8'h01, td, 8'h01, 8'h00);
    rd_reg(4'd14, v);
    wait_cyc(68);
    rd_reg(4'd14, v);
    chk({tag, " first second"}, v, e1);
    wait_cyc(62);
    rd_reg(4'd14, v);
    chk({tag, " second second"}, v, e2);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired R1 act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    wait_cyc(3);
    rst_n = 1'b1;

    // R12 reset state
    chk("R12 irq", {6'd0, irq, irq_oe}, 8'h00);
    rd_reg(4'd0, v); chk("R12 sec", v, 8'h00);
    rd_reg(4'd2, v); chk("R12 hour", v, 8'h00);
    rd_reg(4'd3, v); chk("R12 day", v, 8'h01);
    rd_reg(4'd4, v); chk("R12 date", v, 8'h01);
    rd_reg(4'd5, v); chk("R12 month", v, 8'h01);
    rd_reg(4'd6, v); chk("R12 year", v, 8'h00);
    rd_reg(4'd11, v); chk("R12 amode", v, 8'h00);
    rd_reg(4'd14, v); chk("R12 flags", v, 8'h00);
    rd_reg(4'd15, v); chk("R12 ctl", v, 8'h00);

    // R1 exact tick edge after seconds write
    set_time(8'h05, 8'h10, 8'h20, 8'h02, 8'h03, 8'h04, 8'h05);
    wait_cyc(62);
    rd_reg(4'd0, v); chk("R1 before edge", v, 8'h20);
    rd_reg(4'd0, v); chk("R1 after edge", v, 8'h21);
    wait_cyc(62);
    rd_reg(4'd0, v); chk("R1 next second", v, 8'h22);

    // R2 minute and hour roll, weekday 7 -> 1
    set_time(8'h10, 8'h59, 8'h59, 8'h03, 8'h10, 8'h06, 8'h20);
    wait_cyc(70);
    rd_reg(4'd2, v); chk("R2 hour step", v, 8'h11);
    rd_reg(4'd1, v); chk("R2 min wrap", v, 8'h00);
    rd_reg(4'd3, v); chk("R2 day same", v, 8'h03);
    set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h10, 8'h06, 8'h20);
    wait_cyc(70);
    rd_reg(4'd2, v); chk("R2 hour wrap", v, 8'h00);
    rd_reg(4'd0, v); chk("R2 sec wrap", v, 8'h00);
    rd_reg(4'd3, v); chk("R2 weekday wrap", v, 8'h01);
    rd_reg(4'd4, v); chk("R2 date step", v, 8'h11);

    // R3 month-end sweep, years 0..7 and 10..17
    for (int yb = 0; yb < 16; yb++) begin
      for (int m = 1; m <= 12; m++) begin
        int y;
        y = (yb < 8) ? yb : yb + 2;
        set_time(8'h23, 8'h59, 8'h59, 8'h05, to_bcd(dim(m, y)), to_bcd(m), to_bcd(y));
        wait_cyc(70);
        rd_reg(4'd4, v); chk("R3 date wrap", v, 8'h01);
        rd_reg(4'd5, v); chk("R3 month", v, to_bcd((m == 12) ? 1 : m + 1));
        rd_reg(4'd6, v); chk("R3 year", v, to_bcd((m == 12) ? y + 1 : y));
      end
    end
    set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h28, 8'h02, 8'h12);
    wait_cyc(70);
    rd_reg(4'd4, v); chk("R3 leap feb 28", v, 8'h29);
    set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    wait_cyc(70);
    rd_reg(4'd6, v); chk("R3 year 99 wrap", v, 8'h00);
    rd_reg(4'd5, v); chk("R3 year 99 month", v, 8'h01);

    // R11 freeze, then R10 write-enable
    set_time(8'h01, 8'h02, 8'h03, 8'h01, 8'h01, 8'h01, 8'h00);
    wr_reg(4'd15, 8'h03);
    wait_cyc(70);
    rd_reg(4'd0, v); chk("R11 frozen sec", v, 8'h03);
    wr_reg(4'd15, 8'h02);
    rd_reg(4'd0, v); chk("R11 live sec", v, 8'h04);
    wr_reg(4'd15, 8'h00);
    wr_reg(4'd1, 8'h33);
    rd_reg(4'd1, v); chk("R10 min guarded", v, 8'h02);
    wr_reg(4'd6, 8'h44);
    rd_reg(4'd6, v); chk("R10 year guarded", v, 8'h00);

    // R4 R5 alarm modes
    alarm_case("R4 every sec", 8'h02, 8'h00, 8'h00, 8'h00, 8'h01,
               8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01);
    alarm_case("R4 sec match", 8'h03, 8'h00, 8'h00, 8'h05, 8'h01,
               8'h00, 8'h00, 8'h03, 8'h01, 8'h00, 8'h01);
    alarm_case("R4 min+sec match", 8'h04, 8'h00, 8'h00, 8'h01, 8'h01,
               8'h10, 8'h59, 8'h59, 8'h01, 8'h00, 8'h01);
    alarm_case("R4 min mismatch", 8'h04, 8'h00, 8'h00, 8'h01, 8'h01,
               8'h10, 8'h58, 8'h59, 8'h01, 8'h00, 8'h00);
    alarm_case("R4 hms match", 8'h05, 8'h00, 8'h00, 8'h00, 8'h01,
               8'h23, 8'h59, 8'h59, 8'h01, 8'h01, 8'h00);
    alarm_case("R4 hour mismatch", 8'h05, 8'h00, 8'h00, 8'h00, 8'h01,
               8'h22, 8'h59, 8'h59, 8'h01, 8'h00, 8'h00);
    alarm_case("R4 once wrong date", 8'h01, 8'h12, 8'h30, 8'h00, 8'h15,
               8'h12, 8'h29, 8'h59, 8'h14, 8'h00, 8'h00);
    rd_reg(4'd11, v); chk("R5 once still armed", v, 8'h01);
    alarm_case("R4 once fire", 8'h01, 8'h12, 8'h30, 8'h00, 8'h15,
               8'h12, 8'h29, 8'h59, 8'h15, 8'h01, 8'h00);
    rd_reg(4'd11, v); chk("R5 once disarmed", v, 8'h00);
    alarm_case("R4 off", 8'h00, 8'h00, 8'h00, 8'h00, 8'h01,
               8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00);
    alarm_case("R4 code 7 off", 8'h07, 8'h00, 8'h00, 8'h00, 8'h01,
               8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00);
    wr_reg(4'd11, 8'h00);

    // R6 watchdog, fraction unit, with R8 R9 through the pin
    wr_reg(4'd13, 8'h82);
    rd_reg(4'd14, v);
    wr_reg(4'd12, 8'h05);
    wait_cyc(6);
    rd_reg(4'd14, v); chk("R6 frac early", v, 8'h00);
    wait_cyc(3);
    chk("R9 push-pull active", {6'd0, irq, irq_oe}, 8'h03);
    rd_reg(4'd14, v); chk("R6 frac expired", v, 8'h02);
    chk("R8 cleared quiet", {6'd0, irq, irq_oe}, 8'h01);
    for (int i = 0; i < 10; i++) begin
      wr_reg(4'd12, 8'h05);
      wait_cyc(5);
    end
    rd_reg(4'd14, v); chk("R6 restart holds off", v, 8'h00);
    wait_cyc(20);
    rd_reg(4'd14, v); chk("R6 expires after restarts", v, 8'h02);
    wr_reg(4'd12, 8'h00);
    rd_reg(4'd14, v);
    wait_cyc(200);
    rd_reg(4'd14, v); chk("R6 zero disabled", v, 8'h00);
    wr_reg(4'd12, 8'h82);
    rd_reg(4'd12, v); chk("R6 readback", v, 8'h82);
    rd_reg(4'd14, v);
    wait_cyc(58);
    rd_reg(4'd14, v); chk("R6 sec unit early", v, 8'h00);
    wait_cyc(72);
    rd_reg(4'd14, v); chk("R6 sec unit expired", v, 8'h02);
    wr_reg(4'd12, 8'h00);

    // R7 R8 R9 power-fail path
    wr_reg(4'd13, 8'h04);
    rd_reg(4'd14, v);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); pwr_fail = 1'b0;
    @(negedge clk);
    chk("R9 open-drain", {6'd0, irq, irq_oe}, 8'h01);
    wr_reg(4'd13, 8'h84);
    chk("R9 push-pull", {6'd0, irq, irq_oe}, 8'h03);
    wr_reg(4'd13, 8'h80);
    chk("R8 masked push-pull", {6'd0, irq, irq_oe}, 8'h01);
    wr_reg(4'd13, 8'h03);
    chk("R8 masked open-drain", {6'd0, irq, irq_oe}, 8'h00);
    wr_reg(4'd13, 8'h04);
    rd_reg(4'd14, v); chk("R7 sticky power flag", v, 8'h04);
    rd_reg(4'd14, v); chk("R7 cleared by read", v, 8'h00);
    chk("R8 idle after clear", {6'd0, irq, irq_oe}, 8'h00);
    @(negedge clk); pwr_fail = 1'b1;
    rd_reg(4'd14, v);
    rd_reg(4'd14, v); chk("R7 level re-sets", v, 8'h04);
    pwr_fail = 1'b0;

    finish_run();
  end
endmodule